// File: doc/BRIEF.md
# Shared-Thread Translation Shadow Cache

This block is a small, fully associative cache of page translations that sits in front of a larger unified translation table. It serves four hardware threads that share every slot. Each lookup presents an effective page number, an 8-bit thread tag, the access kind (load or store) and the privilege state. The block compares the lookup against every slot at once. On a hit it returns the real page number and the permission verdict in the same cycle, so the pipeline sees no added latency.

On a miss the block stalls the requester and sends one refill request to the unified table. The returned entry is installed into a victim slot. The stall clears in the cycle after the install, when the same lookup hits. The returned thread tag is 14 bits wide; only its low 8 bits are kept. Slots carry no partition tag.

A single parameter selects the instruction variant (16 slots) or the data variant (32 slots). Only the data variant stores a virtualization-fault bit. Software can write and read any slot by index, one field group at a time. It can also invalidate one slot, or invalidate every slot that is not protected by a nonzero class field.

Top module: `xlat_shadow`

## Requirements
- R1: After reset every slot is invalid. A valid lookup then gives lkHit=0 and lkStall=1, tlbReqValid is 0, and a software read of the tag group of any slot shows its valid bit (bit 30) as 0.
- R2: A slot matches when it is valid and both its effective page and its 8-bit thread tag equal the lookup's. A matching lookup gives lkHit=1, lkStall=0 and that slot's real page on lkRpn in the same cycle.
- R3: A valid lookup with no match holds lkStall=1 from its first cycle until the cycle after the refill is installed. tlbReqValid pulses for exactly one cycle, in the cycle after the first miss cycle, and carries the missing page and thread tag on tlbReqEpn and tlbReqTid.
- R4: A refill response is taken only while a request is outstanding; a response at any other time changes no slot. An installed slot is valid, keeps the low 8 bits of the 14-bit tlbRspTid, and the stalled lookup hits one cycle after the response.
- R5: The refill victim is the lowest-index invalid slot. When all slots are valid, the victim is the first slot at or after a rotating pointer whose class field is zero. The pointer is 0 after reset and moves to victim+1 after each such refill.
- R6: The permission nibble is laid out with supervisor read in bit 0, supervisor write in bit 1, user read in bit 2 and user write in bit 3. The privilege input lkPr is 1 for user state and 0 for supervisor state. On a hit, a load whose read bit for the current privilege state is 0 raises lkRdExc. On a hit, a store whose write bit for the current privilege state is 0 raises lkWrExc.
- R7: In the data variant, a hit on a slot with its fault bit set raises lkVirtFault and suppresses lkRdExc and lkWrExc. In the instruction variant lkVirtFault stays 0.
- R8: When two or more slots match, lkMultiHit=1 and the lowest-index match supplies lkRpn.
- R9: Software access uses a word-select bit. Select 0 is the tag group: page in bits 19:0, thread tag in bits 27:20, class in bits 29:28, valid in bit 30. Select 1 is the data group: real page in bits 23:0, permissions in bits 27:24, fault bit in bit 28. A write changes only the selected group of the indexed slot. A read returns the selected group combinationally.
- R10: A software write in the same cycle as a refill install is dropped.
- R11: invAllEn clears the valid bit of every slot whose class field is zero and leaves the other slots valid. invOneEn clears the valid bit of the slot at invIdx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup present |
| lkEpn | input | 20 | Lookup effective page |
| lkTid | input | 8 | Lookup thread tag |
| lkIsLoad | input | 1 | 1 = load, 0 = store |
| lkPr | input | 1 | 1 = user state, 0 = supervisor state |
| lkHit | output | 1 | Lookup matched a slot |
| lkStall | output | 1 | Lookup missed; requester must hold |
| lkRpn | output | 24 | Real page of the matching slot |
| lkRdExc | output | 1 | Load not permitted |
| lkWrExc | output | 1 | Store not permitted |
| lkVirtFault | output | 1 | Hit slot has the fault bit set |
| lkMultiHit | output | 1 | More than one slot matched |
| tlbReqValid | output | 1 | One-cycle refill request |
| tlbReqEpn | output | 20 | Requested page |
| tlbReqTid | output | 8 | Requested thread tag |
| tlbRspValid | input | 1 | Refill response present |
| tlbRspEpn | input | 20 | Returned page |
| tlbRspTid | input | 14 | Returned thread tag, full width |
| tlbRspRpn | input | 24 | Returned real page |
| tlbRspPerm | input | 4 | Returned permissions |
| tlbRspCls | input | 2 | Returned class field |
| tlbRspVf | input | 1 | Returned fault bit |
| swWrEn | input | 1 | Software write strobe |
| swWrIdx | input | 5 | Software write slot |
| swWs | input | 1 | Software write group select |
| swWrData | input | 31 | Software write data |
| swRdIdx | input | 5 | Software read slot |
| swRdWs | input | 1 | Software read group select |
| swRdData | output | 31 | Software read data |
| invAllEn | input | 1 | Invalidate all unprotected slots |
| invOneEn | input | 1 | Invalidate one slot |
| invIdx | input | 5 | Slot to invalidate |

## Verification
The properties assume the requester keeps a missing lookup asserted and unchanged until it hits, and that the table answers only while a request is outstanding. The directed bench follows both rules during every refill. When it only probes a miss without refilling, it raises and drops lkValid between two clock edges, so no request is launched. The single case that deliberately sends a response with nothing outstanding is checked through a software read, with no lookup present.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } xlatState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic reqLaunch;
    logic refillWr;
    logic swWr;
    logic invAll;
    logic invOne;
  } xlatStrb_t;

  localparam int PERM_W  = 4;
  localparam int PERM_SR = 0;
  localparam int PERM_SW = 1;
  localparam int PERM_UR = 2;
  localparam int PERM_UW = 3;

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lkMiss,
  input  logic      tlbRspValid,
  input  logic      swWrEn,
  input  logic      invAllEn,
  input  logic      invOneEn,
  output xlatStrb_t strb,
  output logic      tlbReqValid
);

  xlatState_e state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (lkMiss) begin
          strb.reqLaunch = 1'b1;
          stateNxt       = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tlbRspValid) begin
          strb.refillWr = 1'b1;
          stateNxt      = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
    // refill owns the array this cycle
    strb.swWr   = swWrEn & ~strb.refillWr;
    strb.invAll = invAllEn;
    strb.invOne = invOneEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      tlbReqValid <= 1'b0;
    end else begin
      state       <= stateNxt;
      tlbReqValid <= strb.reqLaunch;
    end
  end

endmodule

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
#(
  parameter int IS_DATA   = 1,
  parameter int NUM_ENT   = 32,
  parameter int EPN_W     = 20,
  parameter int RPN_W     = 24,
  parameter int TID_W     = 8,
  parameter int TLB_TID_W = 14,
  parameter int CLS_W     = 2,
  parameter int IDX_W     = 5,
  parameter int WORD_W    = 31
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xlatStrb_t            strb,
  input  logic                 lkValid,
  input  logic [EPN_W-1:0]     lkEpn,
  input  logic [TID_W-1:0]     lkTid,
  input  logic                 lkIsLoad,
  input  logic                 lkPr,
  output logic                 lkHit,
  output logic                 lkMiss,
  output logic [RPN_W-1:0]     lkRpn,
  output logic                 lkRdExc,
  output logic                 lkWrExc,
  output logic                 lkVirtFault,
  output logic                 lkMultiHit,
  output logic [EPN_W-1:0]     tlbReqEpn,
  output logic [TID_W-1:0]     tlbReqTid,
  input  logic [EPN_W-1:0]     tlbRspEpn,
  input  logic [TLB_TID_W-1:0] tlbRspTid,
  input  logic [RPN_W-1:0]     tlbRspRpn,
  input  logic [PERM_W-1:0]    tlbRspPerm,
  input  logic [CLS_W-1:0]     tlbRspCls,
  input  logic                 tlbRspVf,
  input  logic [IDX_W-1:0]     swWrIdx,
  input  logic                 swWs,
  input  logic [WORD_W-1:0]    swWrData,
  input  logic [IDX_W-1:0]     swRdIdx,
  input  logic                 swRdWs,
  output logic [WORD_W-1:0]    swRdData,
  input  logic [IDX_W-1:0]     invIdx
);

  localparam int TAG_TID_LSB  = EPN_W;
  localparam int TAG_CLS_LSB  = EPN_W + TID_W;
  localparam int TAG_V        = EPN_W + TID_W + CLS_W;
  localparam int DAT_PERM_LSB = RPN_W;
  localparam int DAT_VF       = RPN_W + PERM_W;

  logic [NUM_ENT-1:0] vld;
  logic [NUM_ENT-1:0] vfQ;
  logic [EPN_W-1:0]   epnQ  [NUM_ENT];
  logic [TID_W-1:0]   tidQ  [NUM_ENT];
  logic [CLS_W-1:0]   clsQ  [NUM_ENT];
  logic [RPN_W-1:0]   rpnQ  [NUM_ENT];
  logic [PERM_W-1:0]  permQ [NUM_ENT];

  logic [IDX_W-1:0]   rrPtr;
  logic [NUM_ENT-1:0] hitVec;
  logic [IDX_W-1:0]   hitIdx;
  logic [NUM_ENT-1:0] wrRefill, wrTag, wrData;
  logic               anyFree;
  logic [IDX_W-1:0]   freeIdx, rrIdx, cand, victim;

  logic unusedTidHi;
  assign unusedTidHi = ^tlbRspTid[TLB_TID_W-1:TID_W];

  // ---------------- associative match ----------------
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_match
    assign hitVec[g] = vld[g] && (epnQ[g] == lkEpn) && (tidQ[g] == lkTid);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  logic [PERM_W-1:0] hitPerm;
  logic              hitVf, permOk;

  always_comb begin
    hitPerm = permQ[hitIdx];
    hitVf   = vfQ[hitIdx];
    if (lkPr) permOk = lkIsLoad ? hitPerm[PERM_UR] : hitPerm[PERM_UW];
    else      permOk = lkIsLoad ? hitPerm[PERM_SR] : hitPerm[PERM_SW];
  end

  assign lkHit       = lkValid & (|hitVec);
  assign lkMiss      = lkValid & ~(|hitVec);
  assign lkRpn       = rpnQ[hitIdx];
  assign lkVirtFault = lkHit & hitVf;
  assign lkRdExc     = lkHit & ~hitVf & lkIsLoad & ~permOk;
  assign lkWrExc     = lkHit & ~hitVf & ~lkIsLoad & ~permOk;
  assign lkMultiHit  = lkValid & (|(hitVec & (hitVec - 1'b1)));

  // ---------------- victim choice ----------------
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
    rrIdx = rrPtr;
    cand  = '0;
    for (int k = NUM_ENT - 1; k >= 0; k--) begin
      cand = rrPtr + IDX_W'(k);
      if (clsQ[cand] == '0) rrIdx = cand;
    end
    victim = anyFree ? freeIdx : rrIdx;
  end

  // ---------------- per-slot write enables ----------------
  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      wrRefill[i] = strb.refillWr && (victim == IDX_W'(i));
      wrTag[i]    = strb.swWr && !swWs && (swWrIdx == IDX_W'(i));
      wrData[i]   = strb.swWr && swWs && (swWrIdx == IDX_W'(i));
    end
  end

  // ---------------- slot storage ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld       <= '0;
      rrPtr     <= '0;
      tlbReqEpn <= '0;
      tlbReqTid <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        epnQ[i]  <= '0;
        tidQ[i]  <= '0;
        clsQ[i]  <= '0;
        rpnQ[i]  <= '0;
        permQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (wrRefill[i]) begin
          vld[i]   <= 1'b1;
          epnQ[i]  <= tlbRspEpn;
          tidQ[i]  <= tlbRspTid[TID_W-1:0];
          clsQ[i]  <= tlbRspCls;
          rpnQ[i]  <= tlbRspRpn;
          permQ[i] <= tlbRspPerm;
        end else if (wrTag[i]) begin
          vld[i]  <= swWrData[TAG_V];
          epnQ[i] <= swWrData[EPN_W-1:0];
          tidQ[i] <= swWrData[TAG_TID_LSB +: TID_W];
          clsQ[i] <= swWrData[TAG_CLS_LSB +: CLS_W];
        end else if (wrData[i]) begin
          rpnQ[i]  <= swWrData[RPN_W-1:0];
          permQ[i] <= swWrData[DAT_PERM_LSB +: PERM_W];
        end else if (strb.invOne && (invIdx == IDX_W'(i))) begin
          vld[i] <= 1'b0;
        end else if (strb.invAll && (clsQ[i] == '0)) begin
          vld[i] <= 1'b0;
        end
      end
      if (strb.refillWr && !anyFree) rrPtr <= victim + 1'b1;
      if (strb.reqLaunch) begin
        tlbReqEpn <= lkEpn;
        tlbReqTid <= lkTid;
      end
    end
  end

  // fault bit only in the data variant
  if (IS_DATA != 0) begin : g_vf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vfQ <= '0;
      end else begin
        for (int i = 0; i < NUM_ENT; i++) begin
          if (wrRefill[i])    vfQ[i] <= tlbRspVf;
          else if (wrData[i]) vfQ[i] <= swWrData[DAT_VF];
        end
      end
    end
  end else begin : g_novf
    logic unusedVf;
    assign unusedVf = tlbRspVf;
    assign vfQ      = '0;
  end

  // ---------------- software read ----------------
  always_comb begin
    if (!swRdWs)
      swRdData = WORD_W'({vld[swRdIdx], clsQ[swRdIdx], tidQ[swRdIdx], epnQ[swRdIdx]});
    else
      swRdData = WORD_W'({vfQ[swRdIdx], permQ[swRdIdx], rpnQ[swRdIdx]});
  end

endmodule

// File: rtl/xlat_shadow.sv
module xlat_shadow
  import xlat_pkg::*;
#(
  parameter int IS_DATA   = 1,
  parameter int NUM_ENT   = (IS_DATA != 0) ? 32 : 16,
  parameter int EPN_W     = 20,
  parameter int RPN_W     = 24,
  parameter int TID_W     = 8,
  parameter int TLB_TID_W = 14,
  parameter int CLS_W     = 2,
  localparam int IDX_W    = $clog2(NUM_ENT),
  localparam int TAG_W    = EPN_W + TID_W + CLS_W + 1,
  localparam int DAT_W    = RPN_W + PERM_W + 1,
  localparam int WORD_W   = (TAG_W > DAT_W) ? TAG_W : DAT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lkValid,
  input  logic [EPN_W-1:0]     lkEpn,
  input  logic [TID_W-1:0]     lkTid,
  input  logic                 lkIsLoad,
  input  logic                 lkPr,
  output logic                 lkHit,
  output logic                 lkStall,
  output logic [RPN_W-1:0]     lkRpn,
  output logic                 lkRdExc,
  output logic                 lkWrExc,
  output logic                 lkVirtFault,
  output logic                 lkMultiHit,
  output logic                 tlbReqValid,
  output logic [EPN_W-1:0]     tlbReqEpn,
  output logic [TID_W-1:0]     tlbReqTid,
  input  logic                 tlbRspValid,
  input  logic [EPN_W-1:0]     tlbRspEpn,
  input  logic [TLB_TID_W-1:0] tlbRspTid,
  input  logic [RPN_W-1:0]     tlbRspRpn,
  input  logic [PERM_W-1:0]    tlbRspPerm,
  input  logic [CLS_W-1:0]     tlbRspCls,
  input  logic                 tlbRspVf,
  input  logic                 swWrEn,
  input  logic [IDX_W-1:0]     swWrIdx,
  input  logic                 swWs,
  input  logic [WORD_W-1:0]    swWrData,
  input  logic [IDX_W-1:0]     swRdIdx,
  input  logic                 swRdWs,
  output logic [WORD_W-1:0]    swRdData,
  input  logic                 invAllEn,
  input  logic                 invOneEn,
  input  logic [IDX_W-1:0]     invIdx
);

  xlatStrb_t strb;
  logic      lkMiss;

  assign lkStall = lkMiss;

  xlat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lkMiss     (lkMiss),
    .tlbRspValid(tlbRspValid),
    .swWrEn     (swWrEn),
    .invAllEn   (invAllEn),
    .invOneEn   (invOneEn),
    .strb       (strb),
    .tlbReqValid(tlbReqValid)
  );

  xlat_dpath #(
    .IS_DATA  (IS_DATA),
    .NUM_ENT  (NUM_ENT),
    .EPN_W    (EPN_W),
    .RPN_W    (RPN_W),
    .TID_W    (TID_W),
    .TLB_TID_W(TLB_TID_W),
    .CLS_W    (CLS_W),
    .IDX_W    (IDX_W),
    .WORD_W   (WORD_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .lkValid    (lkValid),
    .lkEpn      (lkEpn),
    .lkTid      (lkTid),
    .lkIsLoad   (lkIsLoad),
    .lkPr       (lkPr),
    .lkHit      (lkHit),
    .lkMiss     (lkMiss),
    .lkRpn      (lkRpn),
    .lkRdExc    (lkRdExc),
    .lkWrExc    (lkWrExc),
    .lkVirtFault(lkVirtFault),
    .lkMultiHit (lkMultiHit),
    .tlbReqEpn  (tlbReqEpn),
    .tlbReqTid  (tlbReqTid),
    .tlbRspEpn  (tlbRspEpn),
    .tlbRspTid  (tlbRspTid),
    .tlbRspRpn  (tlbRspRpn),
    .tlbRspPerm (tlbRspPerm),
    .tlbRspCls  (tlbRspCls),
    .tlbRspVf   (tlbRspVf),
    .swWrIdx    (swWrIdx),
    .swWs       (swWs),
    .swWrData   (swWrData),
    .swRdIdx    (swRdIdx),
    .swRdWs     (swRdWs),
    .swRdData   (swRdData),
    .invIdx     (invIdx)
  );

endmodule

// File: rtl/xlat_shadow_chk.sv
module xlat_shadow_chk #(
  parameter int IS_DATA = 1
) (
  input logic clk,
  input logic rstN,
  input logic lkHit,
  input logic lkStall,
  input logic lkRdExc,
  input logic lkWrExc,
  input logic lkVirtFault,
  input logic lkMultiHit,
  input logic tlbReqValid
);

  // R2: a hit never stalls
  a_r2_hit_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> !lkStall);

  // R3: request is a single-cycle pulse
  a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tlbReqValid |=> !tlbReqValid);

  // R3: request only follows a stalled lookup
  a_r3_req_after_stall: assert property (@(posedge clk) disable iff (!rstN)
    tlbReqValid |-> $past(lkStall));

  // R6: permission exceptions only on a hit, never both
  a_r6_exc_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    (lkRdExc || lkWrExc) |-> (lkHit && !(lkRdExc && lkWrExc)));

  // R7: fault suppresses access exceptions
  a_r7_vf_excl: assert property (@(posedge clk) disable iff (!rstN)
    lkVirtFault |-> (!lkRdExc && !lkWrExc && lkHit));

  // R7: instruction variant never faults
  a_r7_vf_variant: assert property (@(posedge clk) disable iff (!rstN)
    (IS_DATA == 0) && lkHit |-> !lkVirtFault);

  // R8: multihit implies a hit
  a_r8_multi_hit: assert property (@(posedge clk) disable iff (!rstN)
    lkMultiHit |-> lkHit);

endmodule

bind xlat_shadow xlat_shadow_chk #(.IS_DATA(IS_DATA)) u_chk (.*);

// File: tb/xlat_shadow_tb.sv
module xlat_shadow_tb;

  localparam int CLK_PER = 10;
  localparam int LAT     = 19;   // data variant refill penalty
  localparam int NENT    = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [19:0] lkEpn = '0;
  logic [7:0]  lkTid = '0;
  logic        lkIsLoad = 1'b0;
  logic        lkPr = 1'b0;
  logic        lkHit, lkStall, lkRdExc, lkWrExc, lkVirtFault, lkMultiHit;
  logic [23:0] lkRpn;
  logic        tlbReqValid;
  logic [19:0] tlbReqEpn;
  logic [7:0]  tlbReqTid;
  logic        tlbRspValid = 1'b0;
  logic [19:0] tlbRspEpn = '0;
  logic [13:0] tlbRspTid = '0;
  logic [23:0] tlbRspRpn = '0;
  logic [3:0]  tlbRspPerm = '0;
  logic [1:0]  tlbRspCls = '0;
  logic        tlbRspVf = 1'b0;
  logic        swWrEn = 1'b0;
  logic [4:0]  swWrIdx = '0;
  logic        swWs = 1'b0;
  logic [30:0] swWrData = '0;
  logic [4:0]  swRdIdx = '0;
  logic        swRdWs = 1'b0;
  logic [30:0] swRdData;
  logic        invAllEn = 1'b0;
  logic        invOneEn = 1'b0;
  logic [4:0]  invIdx = '0;

  int nChk = 0;
  int nErr = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  xlat_shadow u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] mkTag(input logic v, input logic [1:0] cls,
                                        input logic [7:0] tid, input logic [19:0] epn);
    return {v, cls, tid, epn};
  endfunction

  function automatic logic [30:0] mkData(input logic vf, input logic [3:0] perm,
                                         input logic [23:0] rpn);
    return {2'b00, vf, perm, rpn};
  endfunction

  task automatic swWrite(input int idx, input logic ws, input logic [30:0] d);
    @(negedge clk);
    swWrEn = 1'b1; swWrIdx = 5'(idx); swWs = ws; swWrData = d;
    @(negedge clk);
    swWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input int idx, input logic ws, input logic [30:0] exp);
    swRdIdx = 5'(idx); swRdWs = ws;
    #1;
    chk(req, swRdData, exp);
  endtask

  // combinational probe, lookup dropped before the next edge
  task automatic probe(input logic [19:0] epn, input logic [7:0] tid,
                       input logic ld, input logic pr);
    @(negedge clk);
    lkValid = 1'b1; lkEpn = epn; lkTid = tid; lkIsLoad = ld; lkPr = pr;
    #1;
  endtask

  task automatic probeEnd;
    #1 lkValid = 1'b0;
  endtask

  task automatic refill(input logic [19:0] epn, input logic [13:0] tid14,
                        input logic [23:0] rpn, input logic [3:0] perm,
                        input logic [1:0] cls, input bit collide, input int colIdx);
    @(negedge clk);
    lkValid = 1'b1; lkEpn = epn; lkTid = tid14[7:0]; lkIsLoad = 1'b1; lkPr = 1'b1;
    #1;
    chk("R3 stall on miss", lkStall, 1'b1);
    chk("R3 no hit on miss", lkHit, 1'b0);
    @(negedge clk); #1;
    chk("R3 request raised", tlbReqValid, 1'b1);
    chk("R3 request page", tlbReqEpn, epn);
    chk("R3 request tag", tlbReqTid, tid14[7:0]);
    @(negedge clk); #1;
    chk("R3 request single pulse", tlbReqValid, 1'b0);
    repeat (LAT - 2) @(negedge clk);
    tlbRspValid = 1'b1; tlbRspEpn = epn; tlbRspTid = tid14; tlbRspRpn = rpn;
    tlbRspPerm = perm; tlbRspCls = cls; tlbRspVf = 1'b0;
    if (collide) begin
      swWrEn = 1'b1; swWrIdx = 5'(colIdx); swWs = 1'b0;
      swWrData = mkTag(1'b1, 2'd0, 8'h11, 20'h0BEEF);
    end
    #1;
    chk("R3 stall until install", lkStall, 1'b1);
    @(negedge clk);
    tlbRspValid = 1'b0; swWrEn = 1'b0;
    #1;
    chk("R4 hit after install", lkHit, 1'b1);
    chk("R3 stall cleared", lkStall, 1'b0);
    chk("R2 refilled rpn", lkRpn, rpn);
    lkValid = 1'b0;
  endtask

  task automatic tReset;
    probe(20'h00042, 8'h01, 1'b1, 1'b0);
    chk("R1 reset miss stalls", lkStall, 1'b1);
    chk("R1 reset no hit", lkHit, 1'b0);
    chk("R1 reset no request", tlbReqValid, 1'b0);
    probeEnd();
    rdChk("R1 slot invalid at reset", 7, 1'b0, '0);
  endtask

  task automatic tIdleRsp;
    @(negedge clk);
    tlbRspValid = 1'b1; tlbRspEpn = 20'h00777; tlbRspTid = 14'h0001; tlbRspRpn = 24'h1;
    @(negedge clk);
    tlbRspValid = 1'b0;
    rdChk("R4 idle response ignored", 0, 1'b0, '0);
  endtask

  task automatic tFirstRefill;
    refill(20'h12345, 14'h3F05, 24'hABCDE, 4'b0100, 2'd0, 1'b0, 0);
    rdChk("R4 R5 slot0 tag narrowed", 0, 1'b0, mkTag(1'b1, 2'd0, 8'h05, 20'h12345));
    rdChk("R9 slot0 data group", 0, 1'b1, mkData(1'b0, 4'b0100, 24'hABCDE));
    probe(20'h12345, 8'h05, 1'b1, 1'b1);
    chk("R6 user load allowed", lkRdExc, 1'b0);
    probeEnd();
    probe(20'h12345, 8'h06, 1'b1, 1'b1);
    chk("R2 other thread tag misses", lkHit, 1'b0);
    probeEnd();
  endtask

  task automatic tPerm;
    swWrite(3, 1'b1, mkData(1'b0, 4'b0000, 24'h000333));
    swWrite(3, 1'b0, mkTag(1'b1, 2'd0, 8'h03, 20'h00300));
    probe(20'h00300, 8'h03, 1'b1, 1'b0);
    chk("R6 supervisor load denied", lkRdExc, 1'b1);
    chk("R2 hit rpn slot3", lkRpn, 24'h000333);
    probeEnd();
    swWrite(3, 1'b1, mkData(1'b0, 4'b0001, 24'h000333));
    rdChk("R9 tag kept on data write", 3, 1'b0, mkTag(1'b1, 2'd0, 8'h03, 20'h00300));
    probe(20'h00300, 8'h03, 1'b1, 1'b0);
    chk("R6 supervisor load allowed", lkRdExc, 1'b0);
    probeEnd();
    swWrite(3, 1'b1, mkData(1'b0, 4'b0111, 24'h000333));
    probe(20'h00300, 8'h03, 1'b0, 1'b1);
    chk("R6 user store denied", lkWrExc, 1'b1);
    chk("R6 store gives no read exc", lkRdExc, 1'b0);
    probeEnd();
    swWrite(3, 1'b1, mkData(1'b0, 4'b1000, 24'h000333));
    probe(20'h00300, 8'h03, 1'b0, 1'b1);
    chk("R6 user store allowed", lkWrExc, 1'b0);
    probeEnd();
  endtask

  task automatic tVf;
    swWrite(4, 1'b1, mkData(1'b1, 4'b0000, 24'h000444));
    swWrite(4, 1'b0, mkTag(1'b1, 2'd0, 8'h04, 20'h00400));
    rdChk("R9 fault bit readback", 4, 1'b1, mkData(1'b1, 4'b0000, 24'h000444));
    probe(20'h00400, 8'h04, 1'b1, 1'b0);
    chk("R7 fault raised", lkVirtFault, 1'b1);
    chk("R7 read exc suppressed", lkRdExc, 1'b0);
    probeEnd();
  endtask

  task automatic tMulti;
    swWrite(5, 1'b1, mkData(1'b0, 4'b1111, 24'h000555));
    swWrite(5, 1'b0, mkTag(1'b1, 2'd0, 8'h09, 20'h00900));
    swWrite(6, 1'b1, mkData(1'b0, 4'b1111, 24'h000666));
    swWrite(6, 1'b0, mkTag(1'b1, 2'd2, 8'h09, 20'h00900));
    probe(20'h00900, 8'h09, 1'b1, 1'b1);
    chk("R8 multihit flagged", lkMultiHit, 1'b1);
    chk("R8 lowest index used", lkRpn, 24'h000555);
    probeEnd();
  endtask

  task automatic tInval;
    @(negedge clk); invAllEn = 1'b1;
    @(negedge clk); invAllEn = 1'b0;
    rdChk("R11 unprotected slot cleared", 5, 1'b0, mkTag(1'b0, 2'd0, 8'h09, 20'h00900));
    rdChk("R11 protected slot kept", 6, 1'b0, mkTag(1'b1, 2'd2, 8'h09, 20'h00900));
    probe(20'h00900, 8'h09, 1'b1, 1'b1);
    chk("R11 survivor hits", lkRpn, 24'h000666);
    chk("R8 no multihit after clear", lkMultiHit, 1'b0);
    probeEnd();
    @(negedge clk); invOneEn = 1'b1; invIdx = 5'd6;
    @(negedge clk); invOneEn = 1'b0;
    probe(20'h00900, 8'h09, 1'b1, 1'b1);
    chk("R11 single invalidate", lkStall, 1'b1);
    probeEnd();
  endtask

  task automatic tCollide;
    refill(20'h0A0A0, 14'h0002, 24'h00A0A0, 4'b1111, 2'd0, 1'b1, 10);
    rdChk("R10 write dropped", 10, 1'b0, '0);
    rdChk("R5 lowest free slot", 0, 1'b0, mkTag(1'b1, 2'd0, 8'h02, 20'h0A0A0));
  endtask

  task automatic tRoundRobin;
    for (int i = 0; i < NENT; i++)
      swWrite(i, 1'b0, mkTag(1'b1, (i == 0) ? 2'd1 : 2'd0, 8'h00, 20'(32'h100 + i)));
    refill(20'h00777, 14'h0000, 24'h000777, 4'b1111, 2'd0, 1'b0, 0);
    rdChk("R5 protected slot skipped", 1, 1'b0, mkTag(1'b1, 2'd0, 8'h00, 20'h00777));
    rdChk("R5 protected slot intact", 0, 1'b0, mkTag(1'b1, 2'd1, 8'h00, 20'h00100));
    refill(20'h00778, 14'h0000, 24'h000778, 4'b1111, 2'd0, 1'b0, 0);
    rdChk("R5 pointer advanced", 2, 1'b0, mkTag(1'b1, 2'd0, 8'h00, 20'h00778));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tIdleRsp();
    tFirstRefill();
    tPerm();
    tVf();
    tMulti();
    tInval();
    tCollide();
    tRoundRobin();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule